// File: doc/BRIEF.md
# Cascadable Reference-Compare Timer Pair

Two 16-bit up-counting timers sit behind one small register interface. Each has a mode register, a reference register, a counter and an event register. When a counter is about to reach its reference, the timer records a reference event. In restart mode the counter then returns to zero, so the next period begins with no idle cycle. In free-run mode the counter carries on and wraps past 0xFFFF. Each timer picks its count input from one of four sources: the system clock, the system clock divided by 16, the reference pulses of the other timer, or nothing. An 8-bit prescaler then divides that input.

A cascade bit in the global control register joins the pair into one 32-bit timer. Timer 1 holds the upper half and timer 2 the lower half. The lower counter's carry advances the upper counter, and the match is taken on the full 32-bit value. One 32-bit access to timer 1's counter or reference address writes or reads both halves at once. In this mode only timer 1 reports events. Software programs the pair by writing the mode and reference registers while the timers are disabled, then sets the enable bits.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every counter reads 0, every event register reads 0, every mode register reads 0x0000, every reference reads 0xFFFF and both interrupt outputs are low.
- R2: While a timer's enable bit is clear, its counter reads 0 and ignores writes. Its mode and reference registers still accept writes and read them back.
- R3: In restart mode (mode bit 3 = 1), the system clock as source and a prescaler of 0, a reference of N makes the counter count 0..N-1. At every Nth clock after enable, the counter returns to 0 and sets event bit 1.
- R4: In free-run mode (mode bit 3 = 0), the counter sets event bit 1 when it reaches the reference and keeps counting. After 0xFFFF it wraps to 0.
- R5: Mode bits [15:8] hold a prescaler value P. The counter then advances once every P+1 ticks of the selected source.
- R6: Mode bits [2:1] select the count source: 01 is the system clock, 10 is the system clock divided by 16, 11 stops counting, and 00 (when not cascaded) uses the reference pulses of the other timer, one clock later.
- R7: The event register is write-one-to-clear. Writing 1 to bit 1 clears the event, and writing 0 to it leaves the event set.
- R8: A timer's interrupt output is high exactly when its event bit 1 and its mode bit 4 are both set. In cascade mode, timer 2's interrupt stays low even with an event pending.
- R9: In cascade mode, a 32-bit write to timer 1's counter address (3) or reference address (2) loads timer 1 from data bits [31:16] and timer 2 from bits [15:0]. A read of either address returns both halves in the same layout.
- R10: In cascade mode the pair counts as one 32-bit value that advances at timer 2's prescaled rate. A carry out of the lower half increments the upper half. A 32-bit match sets timer 1's event and, with timer 2's restart bit set, clears both halves. Timer 2's event is never set.
- R11: Global control bit 0 enables timer 1, bit 4 enables timer 2 and bit 7 selects cascade mode. In cascade mode the pair counts only when both enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wide_i | input | 1 | Marks a 32-bit access |
| addr_i | input | 4 | Register address: 0 control, 1-4 timer 1 mode/ref/count/event, 5-8 the same for timer 2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 2 | Interrupt per timer, bit 0 timer 1 |

## Verification
The checker watches several rules on every cycle. A disabled counter holds zero on the next cycle. A pending event survives any cycle without a matching write-one clear. Timer 2's event never rises while the pair is cascaded, and timer 2's interrupt stays low in that mode. A paired counter load lands in both halves at once. Other behaviour can only be shown by the bench's scenarios: the exact match period, the prescaler and divided-clock rates, the free-run wrap, partner clocking, the carry from the lower half into the upper half, and the 32-bit match with restart.

// File: rtl/tmr_pair_pkg.sv
`timescale 1ns/1ps
package tmr_pair_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_REF_HI  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_EVT_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MODE_LO = 4'd5;
  localparam logic [ADDR_W-1:0] A_REF_LO  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_EVT_LO  = 4'd8;

  // control bits
  localparam int unsigned CTL_EN_HI = 0;
  localparam int unsigned CTL_EN_LO = 4;
  localparam int unsigned CTL_CASC  = 7;

  // mode fields
  localparam int unsigned M_SEL_LSB = 1;
  localparam int unsigned M_RESTART = 3;
  localparam int unsigned M_IE      = 4;
  localparam int unsigned M_PSC_LSB = 8;

  localparam int unsigned EVT_BIT = 1;

  typedef enum logic [1:0] {
    SRC_PARTNER = 2'b00,
    SRC_SYS     = 2'b01,
    SRC_SLOW    = 2'b10,
    SRC_OFF     = 2'b11
  } src_e;
endpackage

// File: rtl/tmr_pair_src.sv
`timescale 1ns/1ps
module tmr_pair_src
  import tmr_pair_pkg::*;
#(
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned SLOW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       sel_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             partner_i,
  output logic             tick_o
);
  logic [SLOW_W-1:0] slow_q;
  logic [PSC_W-1:0]  psc_q;
  logic              src;
  logic              wrap;

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_PARTNER: src = partner_i;
      SRC_SYS:     src = 1'b1;
      SRC_SLOW:    src = &slow_q;
      default:     src = 1'b0;
    endcase
    src  = src & run_i;
    // >= tolerates a divider lowered while running
    wrap = psc_q >= div_i;
  end

  assign tick_o = src & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= '0;
      psc_q  <= '0;
    end else if (!run_i) begin
      slow_q <= '0;
      psc_q  <= '0;
    end else begin
      slow_q <= slow_q + SLOW_W'(1);
      if (src) psc_q <= wrap ? '0 : psc_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/tmr_pair_regs.sv
`timescale 1ns/1ps
module tmr_pair_regs
  import tmr_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  wide_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*CNT_W-1:0]    wdata_i,
  input  logic [1:0]            evt_set_i,
  output logic [CNT_W-1:0]      ctrl_o,
  output logic [1:0][CNT_W-1:0] mode_o,
  output logic [1:0][CNT_W-1:0] ref_o,
  output logic [1:0]            evt_o,
  output logic [1:0]            cnt_ld_o,
  output logic [1:0][CNT_W-1:0] cnt_ld_data_o
);
  localparam logic [ADDR_W-1:0] A_MODE [2] = '{A_MODE_HI, A_MODE_LO};
  localparam logic [ADDR_W-1:0] A_REF  [2] = '{A_REF_HI,  A_REF_LO};
  localparam logic [ADDR_W-1:0] A_CNT  [2] = '{A_CNT_HI,  A_CNT_LO};
  localparam logic [ADDR_W-1:0] A_EVT  [2] = '{A_EVT_HI,  A_EVT_LO};

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] wd_lo, wd_hi;
  logic             pair_wr, pair_ref, pair_cnt;

  assign wd_lo    = wdata_i[CNT_W-1:0];
  assign wd_hi    = wdata_i[2*CNT_W-1:CNT_W];
  assign pair_wr  = wr_i & wide_i & ctrl_q[CTL_CASC];
  assign pair_ref = pair_wr & (addr_i == A_REF_HI);
  assign pair_cnt = pair_wr & (addr_i == A_CNT_HI);
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (wr_i && addr_i == A_CTRL)   ctrl_q <= wd_lo;
  end

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    localparam bit IS_HI = (i == 0);
    logic             ref_we;
    logic [CNT_W-1:0] ref_d;
    logic             evt_clr;
    logic [CNT_W-1:0] mode_q, ref_q;
    logic             evt_q;

    // upper half takes the high word of a paired access; lower half is also hit by it
    assign ref_we  = (wr_i & (addr_i == A_REF[i])) | (!IS_HI & pair_ref);
    assign ref_d   = (IS_HI & pair_wr) ? wd_hi : wd_lo;
    assign evt_clr = wr_i & (addr_i == A_EVT[i]) & wdata_i[EVT_BIT];

    assign cnt_ld_o[i]      = (wr_i & (addr_i == A_CNT[i])) | (!IS_HI & pair_cnt);
    assign cnt_ld_data_o[i] = (IS_HI & pair_wr) ? wd_hi : wd_lo;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= '0;
        ref_q  <= '1;
        evt_q  <= 1'b0;
      end else begin
        if (wr_i && addr_i == A_MODE[i]) mode_q <= wd_lo;
        if (ref_we) ref_q <= ref_d;
        evt_q <= evt_set_i[i] | (evt_q & ~evt_clr);
      end
    end

    assign mode_o[i] = mode_q;
    assign ref_o[i]  = ref_q;
    assign evt_o[i]  = evt_q;
  end
endmodule

// File: rtl/tmr_pair_core.sv
`timescale 1ns/1ps
module tmr_pair_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            run_i,
  input  logic                  casc_i,
  input  logic [1:0]            tick_i,
  input  logic [1:0]            restart_i,
  input  logic [1:0][CNT_W-1:0] ref_i,
  input  logic [1:0]            ld_i,
  input  logic [1:0][CNT_W-1:0] ld_data_i,
  output logic [1:0][CNT_W-1:0] cnt_o,
  output logic [1:0]            evt_set_o,
  output logic [1:0]            out_o
);
  localparam int unsigned W2 = 2 * CNT_W;

  logic [1:0][CNT_W-1:0] cnt_q;
  logic [1:0][CNT_W-1:0] nxt;
  logic [1:0]            hit;
  logic [1:0]            out_q;
  logic [W2-1:0]         nxt_w;
  logic                  hit_w;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      nxt[i] = cnt_q[i] + CNT_W'(1);
      hit[i] = run_i[i] & ~ld_i[i] & tick_i[i] & (nxt[i] == ref_i[i]);
    end
    nxt_w = {cnt_q[0], cnt_q[1]} + W2'(1);
    hit_w = run_i[1] & ~(|ld_i) & tick_i[1] & (nxt_w == {ref_i[0], ref_i[1]});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= '0;
    end else begin
      if (casc_i) begin
        if (!run_i[1]) begin
          cnt_q <= '0;
        end else if (|ld_i) begin
          for (int i = 0; i < 2; i++) if (ld_i[i]) cnt_q[i] <= ld_data_i[i];
        end else if (tick_i[1]) begin
          {cnt_q[0], cnt_q[1]} <= (hit_w && restart_i[1]) ? '0 : nxt_w;
        end
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (!run_i[i])       cnt_q[i] <= '0;
          else if (ld_i[i])    cnt_q[i] <= ld_data_i[i];
          else if (tick_i[i])  cnt_q[i] <= (hit[i] && restart_i[i]) ? '0 : nxt[i];
        end
      end
      // registered so two partner-clocked timers form no loop
      out_q <= casc_i ? 2'b00 : hit;
    end
  end

  assign cnt_o     = cnt_q;
  assign out_o     = out_q;
  assign evt_set_o = casc_i ? {1'b0, hit_w} : hit;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned SLOW_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 wide_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2*CNT_W-1:0]   wdata_i,
  output logic [2*CNT_W-1:0]   rdata_o,
  output logic [1:0]           irq_o
);
  localparam int unsigned W2 = 2 * CNT_W;

  logic [CNT_W-1:0]      ctrl_q;
  logic [1:0][CNT_W-1:0] mode_q, ref_q, cnt_q, ld_data;
  logic [1:0]            evt_q, evt_set, ld, tick, out_w, run, restart;
  logic                  casc;

  assign casc   = ctrl_q[CTL_CASC];
  assign run[0] = ctrl_q[CTL_EN_HI] & (~casc | ctrl_q[CTL_EN_LO]);
  assign run[1] = ctrl_q[CTL_EN_LO] & (~casc | ctrl_q[CTL_EN_HI]);

  tmr_pair_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wide_i       (wide_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .evt_set_i    (evt_set),
    .ctrl_o       (ctrl_q),
    .mode_o       (mode_q),
    .ref_o        (ref_q),
    .evt_o        (evt_q),
    .cnt_ld_o     (ld),
    .cnt_ld_data_o(ld_data)
  );

  for (genvar i = 0; i < 2; i++) begin : g_src
    assign restart[i] = mode_q[i][M_RESTART];
    tmr_pair_src #(.PSC_W(PSC_W), .SLOW_W(SLOW_W)) u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run[i]),
      .sel_i    (mode_q[i][M_SEL_LSB +: 2]),
      .div_i    (mode_q[i][M_PSC_LSB +: PSC_W]),
      .partner_i(out_w[1-i]),
      .tick_o   (tick[i])
    );
  end

  tmr_pair_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .casc_i   (casc),
    .tick_i   (tick),
    .restart_i(restart),
    .ref_i    (ref_q),
    .ld_i     (ld),
    .ld_data_i(ld_data),
    .cnt_o    (cnt_q),
    .evt_set_o(evt_set),
    .out_o    (out_w)
  );

  assign irq_o[0] = evt_q[0] & mode_q[0][M_IE];
  assign irq_o[1] = evt_q[1] & mode_q[1][M_IE] & ~casc;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:    rdata_o = W2'(ctrl_q);
      A_MODE_HI: rdata_o = W2'(mode_q[0]);
      A_REF_HI:  rdata_o = casc ? {ref_q[0], ref_q[1]} : W2'(ref_q[0]);
      A_CNT_HI:  rdata_o = casc ? {cnt_q[0], cnt_q[1]} : W2'(cnt_q[0]);
      A_EVT_HI:  rdata_o = W2'(evt_q[0]) << EVT_BIT;
      A_MODE_LO: rdata_o = W2'(mode_q[1]);
      A_REF_LO:  rdata_o = W2'(ref_q[1]);
      A_CNT_LO:  rdata_o = W2'(cnt_q[1]);
      A_EVT_LO:  rdata_o = W2'(evt_q[1]) << EVT_BIT;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk
  import tmr_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic                  wide_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [2*CNT_W-1:0]    wdata_i,
  input logic [CNT_W-1:0]      ctrl_i,
  input logic [1:0][CNT_W-1:0] cnt_i,
  input logic [1:0]            evt_i,
  input logic [1:0]            irq_i
);
  p_hi_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CTL_EN_HI] |=> cnt_i[0] == '0);

  p_lo_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CTL_EN_LO] |=> cnt_i[1] == '0);

  p_hi_evt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] && !(wr_i && addr_i == A_EVT_HI && wdata_i[EVT_BIT]) |=> evt_i[0]);

  p_lo_evt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[1] && !(wr_i && addr_i == A_EVT_LO && wdata_i[EVT_BIT]) |=> evt_i[1]);

  p_lo_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[CTL_CASC] |=> !$rose(evt_i[1]));

  p_lo_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[CTL_CASC] |-> !irq_i[1]);

  p_hi_irq_needs_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] |-> evt_i[0]);

  p_pair_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wide_i && addr_i == A_CNT_HI && ctrl_i[CTL_CASC]
      && ctrl_i[CTL_EN_HI] && ctrl_i[CTL_EN_LO]
    |=> {cnt_i[0], cnt_i[1]} == $past(wdata_i));
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .wide_i (wide_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .ctrl_i (ctrl_q),
  .cnt_i  (cnt_q),
  .evt_i  (evt_q),
  .irq_i  (irq_o)
);

// File: tb/tmr_pair_bench.sv
`timescale 1ns/1ps
module tmr_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .wr_i   (wr_i),
    .wide_i (wide_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit wide = 1'b0);
    @(negedge clk);
    wr_i = 1'b1; wide_i = wide; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    wr_i = 1'b0; wide_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; #0.1;
    d = rdata_o;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected count for the restart / free-run model of R3, R4, R5
  function automatic int exp_cnt(int k, int p, int rf, bit rs);
    int t = k / (p + 1);
    return rs ? t % rf : t;
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'h0000_5eed));
    #12 rst_n = 1'b1;
    #1;

    // R1 reset values
    rd(4'd2, v); chk("R1 ref1", v, 32'hFFFF);
    rd(4'd6, v); chk("R1 ref2", v, 32'hFFFF);
    rd(4'd1, v); chk("R1 mode1", v, 0);
    rd(4'd7, v); chk("R1 cnt2", v, 0);
    rd(4'd4, v); chk("R1 evt1", v, 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R2 disabled timer
    wr(4'd7, 32'h1234);
    rd(4'd7, v); chk("R2 cnt2 write ignored", v, 0);
    wr(4'd6, 32'h0042);
    rd(4'd6, v); chk("R2 ref2 writable", v, 32'h42);
    wr(4'd5, 32'h0300);
    rd(4'd5, v); chk("R2 mode2 writable", v, 32'h0300);

    // R3 restart, ref 250, divide by 1; R7 write-one-to-clear; R8 irq
    wr(4'd5, 32'h001A);
    wr(4'd6, 32'd250);
    wr(4'd0, 32'h0010);
    step(249);
    rd(4'd7, v); chk("R3 cnt before match", v, 249);
    rd(4'd8, v); chk("R3 no event yet", v, 0);
    step(1);
    rd(4'd7, v); chk("R3 cnt restarts", v, 0);
    rd(4'd8, v); chk("R3 event at 250", v, 2);
    chk("R8 irq2 on", 32'(irq_o), 32'b10);
    wr(4'd8, 32'h0000);
    rd(4'd8, v); chk("R7 zero write keeps event", v, 2);
    wr(4'd8, 32'h0002);
    rd(4'd8, v); chk("R7 one write clears", v, 0);
    step(247);
    rd(4'd8, v); chk("R3 no event at 499", v, 0);
    step(1);
    rd(4'd8, v); chk("R3 event at 500", v, 2);
    rd(4'd7, v); chk("R3 cnt at 500", v, 0);
    wr(4'd5, 32'h000A);
    chk("R8 irq masked by mode bit 4", 32'(irq_o), 0);

    // R4 free run and wrap
    wr(4'd0, 0);
    wr(4'd8, 32'hFFFF);
    wr(4'd5, 32'h0002);
    wr(4'd6, 32'd5);
    wr(4'd0, 32'h0010);
    step(7);
    rd(4'd7, v); chk("R4 counts past ref", v, 7);
    rd(4'd8, v); chk("R4 event on reach", v, 2);
    wr(4'd7, 32'hFFFE);
    step(2);
    rd(4'd7, v); chk("R4 wrap to zero", v, 0);

    // R6 source select
    wr(4'd0, 0);
    wr(4'd5, 32'h0006);
    wr(4'd0, 32'h0010);
    step(20);
    rd(4'd7, v); chk("R6 source off", v, 0);
    wr(4'd0, 0);
    wr(4'd5, 32'h0004);
    wr(4'd0, 32'h0010);
    step(40);
    rd(4'd7, v); chk("R6 divide by 16", v, 2);
    wr(4'd0, 0);
    wr(4'd5, 32'h000A);
    wr(4'd6, 32'd4);
    wr(4'd1, 32'h0008);
    wr(4'd2, 32'h0100);
    wr(4'd0, 32'h0011);
    step(14);
    rd(4'd3, v); chk("R6 partner clocking", v, 3);

    // R8 lower irq suppressed in cascade
    wr(4'd5, 32'h001A);
    chk("R8 irq2 before cascade", 32'(irq_o), 32'b10);
    wr(4'd0, 32'h0080);
    chk("R8 irq2 masked in cascade", 32'(irq_o), 0);
    rd(4'd8, v); chk("R8 evt2 still pending", v, 2);

    // R9 / R10 / R11 cascade
    wr(4'd4, 32'hFFFF);
    wr(4'd8, 32'hFFFF);
    wr(4'd1, 32'h0010);
    wr(4'd2, 32'h0001_0005, 1'b1);
    rd(4'd2, v); chk("R9 wide ref read", v, 32'h0001_0005);
    rd(4'd6, v); chk("R9 lower ref", v, 32'h0005);
    wr(4'd0, 32'h0090);
    wr(4'd3, 32'h0000_FFFD, 1'b1);
    step(3);
    rd(4'd3, v); chk("R11 cascade needs both enables", v, 0);
    wr(4'd0, 32'h0091);
    wr(4'd3, 32'h0000_FFFD, 1'b1);
    rd(4'd3, v); chk("R9 wide count load", v, 32'h0000_FFFD);
    step(3);
    rd(4'd3, v); chk("R10 carry into upper", v, 32'h0001_0000);
    rd(4'd7, v); chk("R10 lower half", v, 0);
    step(4);
    rd(4'd3, v); chk("R10 before 32-bit match", v, 32'h0001_0004);
    rd(4'd4, v); chk("R10 no event yet", v, 0);
    step(1);
    rd(4'd3, v); chk("R10 restart both halves", v, 0);
    rd(4'd4, v); chk("R10 upper event", v, 2);
    rd(4'd8, v); chk("R10 lower event suppressed", v, 0);
    chk("R8 upper irq in cascade", 32'(irq_o), 32'b01);

    // R5 / R3 / R4 random trials on timer 2
    for (int n = 0; n < 24; n++) begin
      int p  = $urandom_range(3, 0);
      int rf = $urandom_range(31, 2);
      bit rs = 1'($urandom_range(1, 0));
      int k  = $urandom_range(100, 1);
      int t;
      wr(4'd0, 0);
      wr(4'd8, 32'hFFFF);
      wr(4'd6, 32'(rf));
      wr(4'd5, 32'((p << 8) | (int'(rs) << 3) | 2));
      wr(4'd0, 32'h0010);
      step(k);
      t = k / (p + 1);
      rd(4'd7, v); chk("R5 random count", v, 32'(exp_cnt(k, p, rf, rs)));
      rd(4'd8, v); chk("R5 random event", v, (t >= rf) ? 2 : 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule